// File: doc/BRIEF.md
# Update-Broadcast Coherence Line Controller

This block manages the coherence state and data of one line in a write-back cache that keeps copies consistent by broadcasting written words to the other holders, rather than by invalidating them. A resident line is in one of four states: exclusive-clean, shared-clean, shared-owned or dirty. A line that is not resident is treated as a miss, and there is no invalid state for a resident line. When several caches share a line, the owner responsible for flushing it is the cache that wrote it last.

The processor side presents one access at a time. It holds the request, the write flag, the word index and the write data stable until the controller pulses done. On a miss the controller requests the bus. When the grant arrives it performs a line read, and it samples the shared wire in that same cycle. A write to shared data later requests the bus again and broadcasts the single written word. The snoop side reports the reads and updates of the other caches. The controller answers on the shared wire, supplies the whole line on a flush, and merges any broadcast word it receives. Bus arbitration, memory and victim replacement are handled outside the block. A snoop is never presented in a cycle in which this block holds the grant.

Top module: `dragon_line_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the line state reads 0 (not resident) and no bus request is raised. The state encoding on `state_o` is 0 not resident, 1 exclusive-clean, 2 shared-clean, 3 shared-owned, 4 dirty.
- R2: A read to a non-resident line raises `bus_req_o`. In the granted cycle `bus_cmd_o` is 1 (line read), the line loads `fill_line_i`, and the state becomes 2 if `bus_shared_i` was high in that cycle and 1 otherwise. One cycle later the read completes with the filled word.
- R3: A write miss first performs the R2 line read. If the fill found no sharer, the write completes locally to state 4 with no update. If it found a sharer, the write continues as in R5.
- R4: A write to a line in state 1 or 4 completes in the same cycle it is presented. It stores the word, leaves the state at 4 and raises no bus request.
- R5: A write to a line in state 2 or 3 raises `bus_req_o`. In the granted cycle `bus_cmd_o` is 2 (update), `bus_idx_o` and `bus_data_o` carry the index and word, the local copy is written, and done pulses. The state becomes 3 if `bus_shared_i` was high in that cycle and 4 otherwise.
- R6: A snooped update writes `snp_data_i` into word `snp_idx_i` of a resident line. A line in state 3 moves to 2, and a line in state 2 stays in 2.
- R7: A snooped read moves state 4 to 3 and state 1 to 2, and it leaves states 2 and 3 unchanged.
- R8: A read to a resident line completes in the same cycle it is presented, returns the stored word on `cpu_rdata_o` and raises no bus request.
- R9: `snp_shared_o` is high exactly in a cycle with a snooped read or update while the line is resident.
- R10: In a cycle with a snooped read or update, no processor access is served. Done stays low, and the state changes only as the snoop dictates.
- R11: `snp_flush_o` is high exactly when a snooped read finds the line in state 3 or 4. The whole line is then present on `line_o`, with word i at bits i*DW upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until done |
| cpu_we_i | input | 1 | Access is a write |
| cpu_idx_i | input | IW | Word index within the line |
| cpu_wdata_i | input | DW | Write data |
| cpu_done_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DW | Read data for the indexed word |
| bus_req_o | output | 1 | Bus wanted for a line read or an update |
| bus_gnt_i | input | 1 | Bus granted this cycle |
| bus_cmd_o | output | 2 | Issued transaction: 0 none, 1 line read, 2 update |
| bus_idx_o | output | IW | Word index of an update |
| bus_data_o | output | DW | Word broadcast by an update |
| bus_shared_i | input | 1 | Wired shared response from other caches |
| fill_line_i | input | DW*WORDS | Line data returned by a line read |
| snp_rd_i | input | 1 | Another cache reads this line |
| snp_upd_i | input | 1 | Another cache broadcasts a word of this line |
| snp_idx_i | input | IW | Snooped update word index |
| snp_data_i | input | DW | Snooped update word |
| snp_shared_o | output | 1 | This cache holds a copy |
| snp_flush_o | output | 1 | This cache supplies the line |
| line_o | output | DW*WORDS | Current line contents |
| state_o | output | 3 | Coherence state |

## Verification
The bench walks every starting state through every processor access, with both answers on the shared wire at the fill and at the update. A controller that landed a shared write miss in dirty, or skipped the update, would leave a stale copy in another cache, and the count of update commands and the final state would show it. Snooped reads and updates are applied in every state, including with a processor write held in the same cycle. A design that let the write and the snoop both act would show a done pulse or a dirty state where shared-clean is due. A flush from a clean line, or an owner that kept ownership after another cache's update, shows up as a wrong flush bit or state.

// File: rtl/dragon_line_ctrl.sv
module dragon_line_ctrl #(
  parameter int DW    = 8,
  parameter int WORDS = 4,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LW   = DW * WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [IW-1:0] cpu_idx_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_done_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [1:0]    bus_cmd_o,
  output logic [IW-1:0] bus_idx_o,
  output logic [DW-1:0] bus_data_o,
  input  logic          bus_shared_i,
  input  logic [LW-1:0] fill_line_i,
  input  logic          snp_rd_i,
  input  logic          snp_upd_i,
  input  logic [IW-1:0] snp_idx_i,
  input  logic [DW-1:0] snp_data_i,
  output logic          snp_shared_o,
  output logic          snp_flush_o,
  output logic [LW-1:0] line_o,
  output logic [2:0]    state_o
);
  localparam logic [2:0] S_NP = 3'd0, S_EX = 3'd1, S_SC = 3'd2, S_SM = 3'd3, S_MD = 3'd4;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_UPD = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_UPD} phase_t;

  logic [2:0]    st;
  phase_t        ph;
  logic [DW-1:0] word_q [WORDS];

  wire present = (st != S_NP);
  wire snoop   = snp_rd_i | snp_upd_i;
  wire sole    = (st == S_EX) || (st == S_MD);
  wire owner   = (st == S_SM) || (st == S_MD);
  wire take    = (ph == PH_IDLE) && cpu_req_i && !snoop;
  wire go      = bus_gnt_i && (ph != PH_IDLE);
  wire local_wr = take && cpu_we_i && sole;

  assign cpu_done_o   = (take && present && (!cpu_we_i || sole)) || (go && ph == PH_UPD);
  assign cpu_rdata_o  = word_q[cpu_idx_i];
  assign bus_req_o    = (ph != PH_IDLE);
  assign bus_cmd_o    = !go ? C_NONE : ((ph == PH_RD) ? C_RD : C_UPD);
  assign bus_idx_o    = cpu_idx_i;
  assign bus_data_o   = cpu_wdata_i;
  assign snp_shared_o = snoop && present;
  assign snp_flush_o  = snp_rd_i && owner;
  assign state_o      = st;

  for (genvar g = 0; g < WORDS; g++) begin : g_line
    assign line_o[g*DW +: DW] = word_q[g];
  end

  always_ff @(posedge clk) begin
    if (go && ph == PH_RD) begin
      for (int i = 0; i < WORDS; i++) word_q[i] <= fill_line_i[i*DW +: DW];
    end else if (local_wr || (go && ph == PH_UPD)) begin
      word_q[cpu_idx_i] <= cpu_wdata_i;
    end else if (snp_upd_i && present) begin
      word_q[snp_idx_i] <= snp_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_NP;
      ph <= PH_IDLE;
    end else if (go) begin
      if (ph == PH_RD) st <= bus_shared_i ? S_SC : S_EX;
      else             st <= bus_shared_i ? S_SM : S_MD;
      ph <= PH_IDLE;
    end else if (snoop && present) begin
      case (st)
        S_EX:    st <= S_SC;
        S_MD:    st <= snp_rd_i ? S_SM : S_SC;
        S_SM:    st <= snp_upd_i ? S_SC : S_SM;
        default: st <= st;
      endcase
    end else if (take) begin
      if (!present)      ph <= PH_RD;
      else if (local_wr) st <= S_MD;
      else if (cpu_we_i) ph <= PH_UPD;
    end
  end
endmodule

module dragon_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_i,
  input logic       cpu_we_i,
  input logic       cpu_done_o,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic [1:0] bus_cmd_o,
  input logic       snp_rd_i,
  input logic       snp_upd_i,
  input logic       snp_shared_o,
  input logic       snp_flush_o,
  input logic [2:0] state_o
);
  wire snp = snp_rd_i || snp_upd_i;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> state_o == 3'd0 && !bus_req_o);

  assert_read_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_i && !cpu_we_i && state_o != 3'd0 && !bus_req_o && !snp |-> cpu_done_o);

  assert_excl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_i && cpu_we_i && state_o == 3'd1 && !bus_req_o && !snp |=> state_o == 3'd4 && !bus_req_o);

  assert_fill_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o == 2'd1 |=> (state_o == 3'd1 || state_o == 3'd2) && !bus_req_o);

  assert_update_land_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o == 2'd2 |=> state_o == 3'd3 || state_o == 3'd4);

  assert_owner_demote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_upd_i && !bus_gnt_i && state_o == 3'd3 |=> state_o == 3'd2);

  assert_dirty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rd_i && !bus_gnt_i && state_o == 3'd4 |=> state_o == 3'd3);

  assert_flush_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_o |-> snp_rd_i && (state_o == 3'd3 || state_o == 3'd4));

  assert_shared_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> snp && state_o != 3'd0);

  assert_snoop_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp |-> !cpu_done_o);
endmodule

bind dragon_line_ctrl dragon_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
  .cpu_done_o(cpu_done_o), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_cmd_o(bus_cmd_o), .snp_rd_i(snp_rd_i), .snp_upd_i(snp_upd_i),
  .snp_shared_o(snp_shared_o), .snp_flush_o(snp_flush_o), .state_o(state_o)
);

// File: tb/sim_dragon_line_ctrl.sv
`timescale 1ns/1ps
module sim_dragon_line_ctrl;
  localparam int NP = 0, EX = 1, SC = 2, SM = 3, MD = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [1:0] cpu_idx = 0;
  logic [7:0] cpu_wd = 0;
  logic cpu_done;
  logic [7:0] cpu_rd;
  logic bus_req, bus_gnt = 0, bus_sh = 0;
  logic [1:0] bus_cmd, bus_idx;
  logic [7:0] bus_data;
  logic [31:0] fill = 0;
  logic snp_rd = 0, snp_upd = 0;
  logic [1:0] snp_idx = 0;
  logic [7:0] snp_d = 0;
  logic snp_sh, snp_fl;
  logic [31:0] line;
  logic [2:0] st;

  dragon_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_idx_i(cpu_idx), .cpu_wdata_i(cpu_wd), .cpu_done_o(cpu_done),
    .cpu_rdata_o(cpu_rd), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .bus_cmd_o(bus_cmd), .bus_idx_o(bus_idx), .bus_data_o(bus_data),
    .bus_shared_i(bus_sh), .fill_line_i(fill), .snp_rd_i(snp_rd),
    .snp_upd_i(snp_upd), .snp_idx_i(snp_idx), .snp_data_i(snp_d),
    .snp_shared_o(snp_sh), .snp_flush_o(snp_fl), .line_o(line), .state_o(st)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, seed = 0, m_st = NP;
  logic [31:0] m_line = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_st = NP;
    repeat (2) @(negedge clk);
    #1 chk(st == 3'd0 && !bus_req, "R1 reset state", {28'd0, bus_req, st}, 0);
    rst_n = 1;
    seed++;
    for (int i = 0; i < 4; i++) fill[i*8 +: 8] = 8'(seed * 16 + i);
  endtask

  task automatic cpu_op(input bit we, input int idx, input logic [7:0] wd, input bit shr, input bit shu);
    int e_st = m_st, e_rd = 0, e_up = 0, nrd = 0, nup = 0;
    logic [31:0] e_line = m_line;
    logic [7:0] rv = 0;
    bit done = 0;
    string tag;
    if (m_st == NP) tag = we ? "R3 write miss" : "R2 read miss";
    else if (we) tag = (m_st == EX || m_st == MD) ? "R4 local write" : "R5 shared write";
    else tag = "R8 read hit";
    if (e_st == NP) begin
      e_rd = 1;
      e_st = shr ? SC : EX;
      e_line = fill;
    end
    if (we) begin
      if (e_st == EX || e_st == MD) e_st = MD;
      else begin
        e_up = 1;
        e_st = shu ? SM : MD;
      end
      e_line[idx*8 +: 8] = wd;
    end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_idx = 2'(idx); cpu_wd = wd;
    for (int c = 0; c < 16 && !done; c++) begin
      bus_gnt = bus_req;
      #1;
      if (bus_cmd == 2'd1) begin
        nrd++; bus_sh = shr;
      end else if (bus_cmd == 2'd2) begin
        nup++; bus_sh = shu;
        chk(bus_idx == 2'(idx) && bus_data == wd, "R5 update word", {22'd0, bus_idx, bus_data}, {22'd0, 2'(idx), wd});
      end else bus_sh = 0;
      if (cpu_done) begin
        done = 1; rv = cpu_rd;
      end
      @(negedge clk);
    end
    cpu_req = 0; bus_gnt = 0; bus_sh = 0;
    #1;
    chk(done, {tag, " done"}, 32'(done), 1);
    chk(nrd == e_rd, {tag, " line reads"}, nrd, e_rd);
    chk(nup == e_up, {tag, " updates"}, nup, e_up);
    chk(st == 3'(e_st) && !bus_req, {tag, " state"}, st, e_st);
    chk(line == e_line, {tag, " line"}, line, e_line);
    if (!we) chk(rv == e_line[idx*8 +: 8], {tag, " read data"}, rv, e_line[idx*8 +: 8]);
    m_st = e_st;
    m_line = e_line;
  endtask

  task automatic reach(input int target);
    do_reset();
    case (target)
      EX: cpu_op(0, 0, 8'h00, 0, 0);
      SC: cpu_op(0, 0, 8'h00, 1, 0);
      MD: cpu_op(1, 1, 8'hA5, 0, 0);
      SM: cpu_op(1, 1, 8'h5A, 1, 1);
      default: ;
    endcase
  endtask

  task automatic snoop(input bit is_upd, input int idx, input logic [7:0] d, input bit with_cpu);
    bit e_sh = (m_st != NP);
    bit e_fl = !is_upd && (m_st == MD || m_st == SM);
    int e_st = m_st;
    logic [31:0] e_line = m_line;
    if (e_sh) begin
      if (is_upd) begin
        e_line[idx*8 +: 8] = d;
        e_st = SC;
      end else if (m_st == MD) e_st = SM;
      else if (m_st == EX) e_st = SC;
    end
    @(negedge clk);
    snp_rd = !is_upd; snp_upd = is_upd; snp_idx = 2'(idx); snp_d = d;
    if (with_cpu) begin
      cpu_req = 1; cpu_we = 1; cpu_idx = 2'(idx); cpu_wd = ~d;
    end
    #1;
    chk(snp_sh == e_sh, "R9 shared response", 32'(snp_sh), 32'(e_sh));
    chk(snp_fl == e_fl, "R11 flush", 32'(snp_fl), 32'(e_fl));
    if (e_fl) chk(line == m_line, "R11 flushed line", line, m_line);
    chk(!cpu_done, "R10 cpu stalled by snoop", 32'(cpu_done), 0);
    @(negedge clk);
    snp_rd = 0; snp_upd = 0; cpu_req = 0;
    #1;
    chk(st == 3'(e_st), is_upd ? "R6 state after update" : "R7 state after read", st, e_st);
    chk(line == e_line, is_upd ? "R6 merged line" : "R7 line kept", line, e_line);
    chk(!bus_req, "R10 no bus request after snoop", 32'(bus_req), 0);
    m_st = e_st;
    m_line = e_line;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int starts[5] = '{NP, EX, SC, SM, MD};
    int k = 0;
    foreach (starts[s]) begin
      for (int we = 0; we < 2; we++)
        for (int shr = 0; shr < 2; shr++)
          for (int shu = 0; shu < 2; shu++) begin
            reach(starts[s]);
            k++;
            cpu_op(we[0], k % 4, 8'(k * 7 + 3), shr[0], shu[0]);
            cpu_op(0, (k + 1) % 4, 8'h00, 0, 0);
          end
    end
    foreach (starts[s]) begin
      for (int upd = 0; upd < 2; upd++)
        for (int wc = 0; wc < 2; wc++) begin
          reach(starts[s]);
          k++;
          snoop(upd[0], k % 4, 8'(k * 13 + 1), wc[0]);
          if (m_st != NP) cpu_op(0, k % 4, 8'h00, 0, 0);
        end
    end
    reach(MD);
    snoop(0, 0, 8'h00, 0);
    snoop(1, 2, 8'h3C, 0);
    snoop(0, 0, 8'h00, 1);
    cpu_op(1, 3, 8'hE1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule